// File: doc/BRIEF.md
# Group Bit Shuffle Unit

This block rearranges the bits of a 128-bit value so that groups of symbols are interleaved or separated. The 128-bit source is two 64-bit operands placed side by side. Three 3-bit log2 parameters drive one index-rewriting rule. The first sets the span that is rearranged, the second sets the symbol size, and the third sets the degree of shuffling. A single rule therefore covers every interleave and de-interleave width inside a span, and it replaces a fixed set of interleave patterns. A direction input picks the forward rewrite or its exact inverse.

The permutation itself is combinational. Its result is captured in a one-entry output stage. A new operation is accepted on an input valid/ready handshake, and the result is held until the consumer takes it with an output valid/ready handshake. A parameter set in which the symbol size and the degree together exceed the span is rejected: the error flag is raised and the source passes through unchanged.

Top module: `shuf_group_bits`

## Requirements
- R1: The source is `{opa_i, opb_i}`: `opa_i` fills bits 127..64 and `opb_i` fills bits 63..0. Bit 0 is the least-significant bit of both the source and the result.
- R2: With `inverse_i`=0 and a legal set (x=`span_lg_i`, y=`sym_lg_i`, z=`deg_lg_i`), result bit i is source bit j. Here j is the concatenation, from most to least significant, of i[6:x] (empty when x=7), i[y+z-1:y], i[x-1:y+z] and i[y-1:0].
- R3: With `inverse_i`=1 and a legal set, result bit j(i) is source bit i, where j is the index of R2. This undoes the forward rewrite.
- R4: With a legal set and z=0, the result equals the source in both directions.
- R5: When y+z > x, `err_o` is 1 and the result equals the source. For every legal set `err_o` is 0.
- R6: With x=7, y=2, z=4 and forward direction, result nibble n (bits 4n+3..4n, n=0..15) is the low nibble of source byte n, and result nibble 16+n is the high nibble of source byte n.
- R7: An operation is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both 1. Its result and error flag appear with `out_valid_o`=1 after that same edge. If nothing new is accepted, `out_valid_o` returns to 0 after an edge where `out_ready_i` is 1.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, `in_ready_o` is 0 and `res_o`, `err_o` and `out_valid_o` hold their values. When the consumer then takes the result, a pending input is accepted on the same edge.
- R9: After a synchronous active-low reset, `out_valid_o`=0, `res_o`=0, `err_o`=0 and `in_ready_o`=1.
- R10: The number of ones in an accepted source equals the number of ones in its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Operands and parameters are valid |
| in_ready_o | output | 1 | Unit can accept an operation |
| opa_i | input | 64 | Upper half of the source |
| opb_i | input | 64 | Lower half of the source |
| span_lg_i | input | 3 | log2 of the rearranged span (x) |
| sym_lg_i | input | 3 | log2 of the symbol size (y) |
| deg_lg_i | input | 3 | log2 of the shuffle degree (z) |
| inverse_i | input | 1 | 0 = forward rewrite, 1 = inverse rewrite |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 128 | Rearranged value |
| err_o | output | 1 | Parameter set was illegal |

## Verification
Every result is due exactly one rising edge after its input handshake. The bench therefore drives each operation on a falling edge and samples `res_o`, `err_o` and `out_valid_o` on the next falling edge, half a period after the capturing edge. It sweeps all 512 parameter sets in both directions and compares each result with a reference that builds the source index bit by bit, and for the inverse direction it scatters source bits instead of gathering them. In the stall test the consumer is held off for several cycles, and the bench checks on each falling edge that the held result stays unchanged and that the pending input is taken on the releasing edge.

// File: rtl/shuf_pkg.sv
// Shared definitions for the group bit shuffle unit.
// Assumes: parameter fields are small log2 values (at most index width).
package shuf_pkg;

    // Direction of the index rewrite.
    typedef enum logic {
        SHUF_FWD = 1'b0,
        SHUF_INV = 1'b1
    } shuf_dir_e;

    // A set is illegal when symbol size and degree together exceed the span.
    function automatic logic shuf_cfg_bad(input int span_lg, input int sym_lg, input int deg_lg);
        return (sym_lg + deg_lg) > span_lg;
    endfunction

endpackage

// File: rtl/shuf_cfg_check.sv
// Parameter check for the shuffle unit.
// Flags illegal sets and derives the effective degree for the gather network.
// The inverse rewrite equals the forward one with degree x-y-z, because the
// rewrite rotates the field [x-1:y] and the inverse is the complementary rotation.
// Assumes: inputs are stable for the cycle in which they are used.
module shuf_cfg_check
    import shuf_pkg::*;
#(
    parameter int LG_W = 3
) (
    input  logic [LG_W-1:0] span_lg_i,
    input  logic [LG_W-1:0] sym_lg_i,
    input  logic [LG_W-1:0] deg_lg_i,
    input  shuf_dir_e       dir_i,
    output logic            bad_o,
    output logic [LG_W-1:0] eff_deg_o
);
    localparam int SUM_W = LG_W + 1;

    logic [SUM_W-1:0] sym_plus_deg;
    logic [SUM_W-1:0] comp_deg;

    // Legality of the set and the complementary degree for the inverse.
    always_comb begin
        sym_plus_deg = SUM_W'(sym_lg_i) + SUM_W'(deg_lg_i);
        bad_o        = shuf_cfg_bad(int'(span_lg_i), int'(sym_lg_i), int'(deg_lg_i));
        comp_deg     = SUM_W'(span_lg_i) - sym_plus_deg;
        if (bad_o) begin
            eff_deg_o = '0;
        end else if (dir_i == SHUF_INV) begin
            eff_deg_o = comp_deg[LG_W-1:0];
        end else begin
            eff_deg_o = deg_lg_i;
        end
    end

    // r5_: an illegal set never reports a degree to the network.
    always_comb begin
        if (bad_o) begin
            a_r5_bad_zero_deg: assert (eff_deg_o == '0);
        end
    end

endmodule

// File: rtl/shuf_perm_net.sv
// Gather network: every result bit picks one source bit through a full mux.
// The select of output bit k is the index rewrite of k with fields
// x (span), y (symbol) and d (effective degree).
// Assumes: y+d <= x (the caller bypasses illegal sets).
module shuf_perm_net #(
    parameter int DATA_W = 128,
    parameter int LG_W   = 3
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [LG_W-1:0]   span_lg_i,
    input  logic [LG_W-1:0]   sym_lg_i,
    input  logic [LG_W-1:0]   deg_lg_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int IDX_W = $clog2(DATA_W);

    // Rewrite an index by masking its fields and shifting them into place.
    function automatic logic [IDX_W-1:0] remap(input int k, input int x, input int y, input int d);
        int lo_f;
        int mid_f;
        int hi_f;
        int top_f;
        int j;
        if (y + d > x) begin
            return IDX_W'(k);
        end
        lo_f  = k & ((1 << y) - 1);
        mid_f = (k >> y) & ((1 << d) - 1);
        hi_f  = (k >> (y + d)) & ((1 << (x - y - d)) - 1);
        top_f = (k >> x) << x;
        j     = top_f | (mid_f << (x - d)) | (hi_f << y) | lo_f;
        return IDX_W'(j);
    endfunction

    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        logic [IDX_W-1:0] sel;

        // Select of this output bit.
        always_comb begin
            sel = remap(k, int'(span_lg_i), int'(sym_lg_i), int'(deg_lg_i));
        end

        // Gather the chosen source bit.
        always_comb begin
            res_o[k] = src_i[sel];
        end
    end

endmodule

// File: rtl/shuf_out_stage.sv
// One-entry output stage with valid/ready on both sides.
// Captures data on an input handshake and holds it until the consumer takes it.
// Assumes: synchronous active-low reset.
module shuf_out_stage #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] data_i,
    input  logic              err_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    logic take;

    // Room exists when empty or when the held entry leaves this cycle.
    always_comb begin
        in_ready_o = !out_valid_o || out_ready_i;
        take       = in_valid_i && in_ready_o;
    end

    // Valid flag: set on capture, cleared when the consumer takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
        end else if (take) begin
            out_valid_o <= 1'b1;
        end else if (out_ready_i) begin
            out_valid_o <= 1'b0;
        end
    end

    // Payload: loaded only on an input handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            err_o  <= 1'b0;
        end else if (take) begin
            data_o <= data_i;
            err_o  <= err_i;
        end
    end

    a_r7_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> out_valid_o);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(data_o) && $stable(err_o)));

    a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);

endmodule

// File: rtl/shuf_group_bits.sv
// Group bit shuffle unit: joins two operands, rearranges the bits by a
// log2-parameterised index rewrite (forward or inverse) and registers the
// result behind a valid/ready stage. Illegal sets pass the source through
// with an error flag.
// Assumes: synchronous active-low reset; parameters valid with in_valid_i.
module shuf_group_bits
    import shuf_pkg::*;
#(
    parameter int OP_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid_i,
    output logic                          in_ready_o,
    input  logic [OP_W-1:0]               opa_i,
    input  logic [OP_W-1:0]               opb_i,
    input  logic [$clog2($clog2(2*OP_W)+1)-1:0] span_lg_i,
    input  logic [$clog2($clog2(2*OP_W)+1)-1:0] sym_lg_i,
    input  logic [$clog2($clog2(2*OP_W)+1)-1:0] deg_lg_i,
    input  logic                          inverse_i,
    output logic                          out_valid_o,
    input  logic                          out_ready_i,
    output logic [2*OP_W-1:0]             res_o,
    output logic                          err_o
);
    localparam int DATA_W = 2 * OP_W;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int LG_W   = $clog2(IDX_W + 1);

    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] perm;
    logic [DATA_W-1:0] pick;
    logic              bad;
    logic [LG_W-1:0]   eff_deg;
    shuf_dir_e         dir;

    // Join the operands, upper operand on top.
    always_comb begin
        src = {opa_i, opb_i};
        dir = shuf_dir_e'(inverse_i);
    end

    shuf_cfg_check #(
        .LG_W (LG_W)
    ) u_cfg (
        .span_lg_i (span_lg_i),
        .sym_lg_i  (sym_lg_i),
        .deg_lg_i  (deg_lg_i),
        .dir_i     (dir),
        .bad_o     (bad),
        .eff_deg_o (eff_deg)
    );

    shuf_perm_net #(
        .DATA_W (DATA_W),
        .LG_W   (LG_W)
    ) u_net (
        .src_i     (src),
        .span_lg_i (span_lg_i),
        .sym_lg_i  (sym_lg_i),
        .deg_lg_i  (eff_deg),
        .res_o     (perm)
    );

    // Illegal sets bypass the network.
    always_comb begin
        pick = bad ? src : perm;
    end

    shuf_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .data_i      (pick),
        .err_i       (bad),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .data_o      (res_o),
        .err_o       (err_o)
    );

    a_r5_illegal_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && (int'(sym_lg_i) + int'(deg_lg_i) > int'(span_lg_i)))
        |=> (err_o && res_o == $past({opa_i, opb_i})));

    a_r4_zero_degree: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && deg_lg_i == '0)
        |=> (res_o == $past({opa_i, opb_i})));

    a_r10_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o)
        |=> ($countones(res_o) == $countones($past({opa_i, opb_i}))));

endmodule

// File: tb/tb_shuf_group_bits.sv
// Bench: full sweep of parameter sets in both directions, plus reset,
// example, stall and drain checks. Expected values are built bit by bit.
module tb_shuf_group_bits;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic         in_ready_o;
    logic [63:0]  opa_i = '0;
    logic [63:0]  opb_i = '0;
    logic [2:0]   span_lg_i = '0;
    logic [2:0]   sym_lg_i = '0;
    logic [2:0]   deg_lg_i = '0;
    logic         inverse_i = 1'b0;
    logic         out_valid_o;
    logic         out_ready_i = 1'b1;
    logic [127:0] res_o;
    logic         err_o;

    int checks = 0;
    int failures = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    shuf_group_bits dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .opa_i(opa_i), .opb_i(opb_i), .span_lg_i(span_lg_i), .sym_lg_i(sym_lg_i),
        .deg_lg_i(deg_lg_i), .inverse_i(inverse_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .res_o(res_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    // Reference source index, assembled one bit position at a time.
    function automatic int ref_idx(input int i, input int x, input int y, input int z);
        int j = 0;
        int p = 0;
        for (int b = 0; b < y; b++) begin j |= ((i >> b) & 1) << p; p++; end
        for (int b = y + z; b < x; b++) begin j |= ((i >> b) & 1) << p; p++; end
        for (int b = y; b < y + z; b++) begin j |= ((i >> b) & 1) << p; p++; end
        for (int b = x; b < 7; b++) begin j |= ((i >> b) & 1) << p; p++; end
        return j;
    endfunction

    function automatic logic [127:0] ref_res(input logic [127:0] s, input int x, input int y, input int z, input logic inv);
        logic [127:0] r = '0;
        if (y + z > x) return s;
        for (int i = 0; i < 128; i++) begin
            if (inv) r[ref_idx(i, x, y, z)] = s[i];
            else     r[i] = s[ref_idx(i, x, y, z)];
        end
        return r;
    endfunction

    // Drive one operation at a falling edge, hold for one rising edge.
    task automatic send(input logic [63:0] a, input logic [63:0] b, input int x, input int y, input int z, input logic inv);
        @(negedge clk);
        opa_i = a; opb_i = b;
        span_lg_i = 3'(x); sym_lg_i = 3'(y); deg_lg_i = 3'(z); inverse_i = inv;
        in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [127:0] exp;
        logic [127:0] src;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid_o == 1'b0, "R9 out_valid after reset", 128'(out_valid_o), 128'd0);
        check(res_o == '0, "R9 res after reset", res_o, 128'd0);
        check(err_o == 1'b0, "R9 err after reset", 128'(err_o), 128'd0);
        check(in_ready_o == 1'b1, "R9 in_ready after reset", 128'(in_ready_o), 128'd1);
        rst_n = 1'b1;

        // R1: identity set shows operand placement
        send(64'hA5A5_0000_0000_0001, 64'h8000_0000_0000_00FF, 0, 0, 0, 1'b0);
        check(res_o == {64'hA5A5_0000_0000_0001, 64'h8000_0000_0000_00FF}, "R1 operand placement",
              res_o, {64'hA5A5_0000_0000_0001, 64'h8000_0000_0000_00FF});
        check(res_o[0] == 1'b1 && res_o[64] == 1'b1 && res_o[63] == 1'b1, "R1 bit 0 is lsb",
              128'(res_o[0]), 128'd1);

        // R2 R3 R4 R5 R10: full sweep
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < 8; y++) begin
                for (int z = 0; z < 8; z++) begin
                    for (int d = 0; d < 2; d++) begin
                        rng = next_rand(rng);
                        src[127:64] = rng;
                        rng = next_rand(rng);
                        src[63:0] = rng;
                        exp = ref_res(src, x, y, z, d[0]);
                        send(src[127:64], src[63:0], x, y, z, d[0]);
                        check(out_valid_o == 1'b1, "R7 valid one edge after handshake", 128'(out_valid_o), 128'd1);
                        if (y + z > x) begin
                            check(res_o == src && err_o == 1'b1, "R5 illegal set passes source", res_o, src);
                        end else if (z == 0) begin
                            check(res_o == src && err_o == 1'b0, "R4 zero degree is identity", res_o, src);
                        end else if (d == 0) begin
                            check(res_o == exp && err_o == 1'b0, "R2 forward rewrite", res_o, exp);
                        end else begin
                            check(res_o == exp && err_o == 1'b0, "R3 inverse rewrite", res_o, exp);
                        end
                        check($countones(res_o) == $countones(src), "R10 popcount kept",
                              128'($countones(res_o)), 128'($countones(src)));
                    end
                end
            end
        end

        // R6: nibble split example
        src = 128'hF1E2_D3C4_B5A6_9788_7069_5A4B_3C2D_1E0F;
        for (int n = 0; n < 16; n++) begin
            exp[4*n +: 4]      = src[8*n +: 4];
            exp[64 + 4*n +: 4] = src[8*n + 4 +: 4];
        end
        send(src[127:64], src[63:0], 7, 2, 4, 1'b0);
        check(res_o == exp, "R6 nibble split", res_o, exp);

        // R7: drains after one edge with consumer ready and no new input
        @(negedge clk);
        check(out_valid_o == 1'b0, "R7 drain", 128'(out_valid_o), 128'd0);

        // R8: stall holds the result and blocks input
        out_ready_i = 1'b0;
        send(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 6, 1, 3, 1'b0);
        held = ref_res({64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 6, 1, 3, 1'b0);
        check(res_o == held && out_valid_o, "R8 stalled result", res_o, held);
        check(in_ready_o == 1'b0, "R8 input blocked", 128'(in_ready_o), 128'd0);
        opa_i = 64'h1111_2222_3333_4444; opb_i = 64'h5555_6666_7777_8888;
        span_lg_i = 3'd7; sym_lg_i = 3'd3; deg_lg_i = 3'd1; inverse_i = 1'b1;
        in_valid_i = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(res_o == held && out_valid_o && !in_ready_o, "R8 hold under stall", res_o, held);
        end
        out_ready_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        exp = ref_res({64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, 7, 3, 1, 1'b1);
        check(res_o == exp && out_valid_o, "R8 pending input taken on release", res_o, exp);
        @(negedge clk);
        check(out_valid_o == 1'b0, "R7 idle after release", 128'(out_valid_o), 128'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule